// File: doc/BRIEF.md
# Hex-Float Register File Unit

This block holds four 64-bit registers for base-16 floating-point values. A single operation per cycle arrives as an 8-bit opcode, two 4-bit register fields and a byte address that has already been computed. The unit carries out register-to-register copies and loads and stores through a synchronous memory port that uses byte enables. Byte 0 of every value is the most significant byte and holds the sign and the characteristic. 32-bit values always occupy the left half of a register.

A 32-bit load widens the word to register format by zeroing the right half. A 32-bit copy replaces only the left half. A 32-bit store writes the left half to one of the two word lanes of a doubleword. The unit rejects odd register numbers, register numbers above 6 and misaligned addresses. It rejects them with a one-cycle error pulse and performs nothing for that operation. No arithmetic is done and no condition code is produced.

Top module: `hfp_regfile_unit`

## Requirements
- R1: Registers are numbered 0, 2, 4 and 6 in the 4-bit fields, and all four reset to zero. While reset is active and in the first cycle after it, `mem_rd_en`, `mem_wr_en` and `err_pulse` are low.
- R2: Opcode 0x68 loads the 64-bit doubleword at `op_addr` into register r1, and `op_addr` must be a multiple of 8. Memory byte k of a doubleword (k = 0 is the lowest address) sits on data bits [63-8k -: 8] and on byte enable bit 7-k.
- R3: Opcode 0x78 loads a 32-bit word into the left half (bits 63:32) of r1 and clears the right half, and `op_addr` must be a multiple of 4. When address bit 2 is 0 the word is `mem_rdata[63:32]`, and otherwise it is `mem_rdata[31:0]`.
- R4: Opcode 0x28 copies all 64 bits of register r2 into register r1.
- R5: Opcode 0x38 copies the left half of r2 into the left half of r1 and leaves the right half of r1 unchanged.
- R6: Opcode 0x70 stores the left half of r1 to a 4-byte-aligned address. It uses `mem_be` = 0xF0 with the data on bits 63:32 when address bit 2 is 0, and 0x0F with the data on bits 31:0 when address bit 2 is 1.
- R7: Opcode 0x60 stores all 64 bits of r1 to an 8-byte-aligned address with `mem_be` = 0xFF.
- R8: An odd r1, an r1 above 6, an odd or above-6 r2 on a copy, or a misaligned address on any of the six opcodes raises `err_pulse` for exactly the one cycle after the operation. The operation is then suppressed: no memory access and no register change.
- R9: An operation with any other opcode has no effect and raises no error.
- R10: A memory request appears on the port in the cycle after the operation. Load data is taken from `mem_rdata` one cycle after `mem_rd_en` and written into the register at that edge. An operation that reads the register at that same edge gets the old value, and the new value is seen from the next cycle on.
- R11: When a copy and a load write-back target the same register half at the same edge, the copy's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 8 | Operation code |
| op_r1 | input | 4 | First register field (destination, or source of a store) |
| op_r2 | input | 4 | Second register field (source of a copy) |
| op_addr | input | ADDR_W | Precomputed byte address for loads and stores |
| mem_rdata | input | DATA_W | Load data, valid one cycle after `mem_rd_en` |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | DATA_W | Store data |
| mem_be | output | DATA_W/8 | Store byte enables, bit 7 for byte 0 |
| err_pulse | output | 1 | One-cycle pulse for a rejected operation |

## Verification
A load's delayed write-back can land on the same edge as a later operation that reads or writes the same register. The bench provokes both cases. In the first, it issues a 64-bit load and then, two cycles later, a full store of that register. The store must carry the old contents, and a store one cycle later must carry the loaded value. In the second, it places a full copy into the same destination on the write-back edge and checks through a store that the copied value remains.

// File: rtl/hfp_rf_pkg.sv
package hfp_rf_pkg;

  localparam logic [7:0] OPC_LD64 = 8'h68;
  localparam logic [7:0] OPC_LD32 = 8'h78;
  localparam logic [7:0] OPC_CP64 = 8'h28;
  localparam logic [7:0] OPC_CP32 = 8'h38;
  localparam logic [7:0] OPC_ST32 = 8'h70;
  localparam logic [7:0] OPC_ST64 = 8'h60;

  typedef enum logic [2:0] {
    K_NONE,
    K_LD64,
    K_LD32,
    K_CP64,
    K_CP32,
    K_ST32,
    K_ST64
  } op_kind_e;

endpackage

// File: rtl/hfp_op_decode.sv
module hfp_op_decode
  import hfp_rf_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int FIELD_W  = 4,
  parameter int DATA_W   = 64,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int AL_W     = $clog2(DATA_W / 8)
) (
  input  logic               op_valid,
  input  logic [7:0]         op_code,
  input  logic [FIELD_W-1:0] op_r1,
  input  logic [FIELD_W-1:0] op_r2,
  input  logic [AL_W-1:0]    addr_lo,
  output op_kind_e           kind,
  output logic               err,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [IDX_W-1:0]   rd_idx,
  output logic               lane_lo
);

  // even field whose half-value names an existing register
  function automatic logic field_ok(input logic [FIELD_W-1:0] f);
    return (f[0] == 1'b0) && ((int'(f) >> 1) < NUM_REGS);
  endfunction

  op_kind_e raw;
  logic     is_copy;
  logic     misaligned;
  logic     bad;

  always_comb begin
    case (op_code)
      OPC_LD64: raw = K_LD64;
      OPC_LD32: raw = K_LD32;
      OPC_CP64: raw = K_CP64;
      OPC_CP32: raw = K_CP32;
      OPC_ST32: raw = K_ST32;
      OPC_ST64: raw = K_ST64;
      default:  raw = K_NONE;
    endcase
  end

  always_comb begin
    is_copy    = (raw == K_CP64) || (raw == K_CP32);
    misaligned = 1'b0;
    if (raw == K_LD64 || raw == K_ST64)
      misaligned = (addr_lo != '0);
    else if (raw == K_LD32 || raw == K_ST32)
      misaligned = (addr_lo[AL_W-2:0] != '0);
    bad  = !field_ok(op_r1) || (is_copy && !field_ok(op_r2)) || misaligned;
    err  = op_valid && (raw != K_NONE) && bad;
    kind = (op_valid && !bad) ? raw : K_NONE;
  end

  assign wr_idx  = op_r1[IDX_W:1];
  assign rd_idx  = is_copy ? op_r2[IDX_W:1] : op_r1[IDX_W:1];
  assign lane_lo = addr_lo[AL_W-1];

endmodule

// File: rtl/hfp_reg_bank.sv
module hfp_reg_bank #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 64,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  // port A: register copies, wins on a collision
  input  logic              a_we_hi,
  input  logic              a_we_lo,
  input  logic [IDX_W-1:0]  a_idx,
  input  logic [DATA_W-1:0] a_data,
  // port B: load write-back
  input  logic              b_we_hi,
  input  logic              b_we_lo,
  input  logic [IDX_W-1:0]  b_idx,
  input  logic [DATA_W-1:0] b_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] regs_w [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic a_hit, b_hit;

    assign a_hit = (a_idx == IDX_W'(g));
    assign b_hit = (b_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else begin
        if (a_we_hi && a_hit)      q[DATA_W-1:HALF] <= a_data[DATA_W-1:HALF];
        else if (b_we_hi && b_hit) q[DATA_W-1:HALF] <= b_data[DATA_W-1:HALF];
        if (a_we_lo && a_hit)      q[HALF-1:0] <= a_data[HALF-1:0];
        else if (b_we_lo && b_hit) q[HALF-1:0] <= b_data[HALF-1:0];
      end
    end

    assign regs_w[g] = q;
  end

  assign rd_data = regs_w[rd_idx];

endmodule

// File: rtl/hfp_load_path.sv
module hfp_load_path #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              issue_half,
  input  logic              issue_lane_lo,
  input  logic [IDX_W-1:0]  issue_idx,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              wr_hi,
  output logic              wr_lo,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data
);

  localparam int HALF = DATA_W / 2;

  logic             s1_v, s2_v;
  logic             s1_half, s2_half;
  logic             s1_lane, s2_lane;
  logic [IDX_W-1:0] s1_idx, s2_idx;
  logic [HALF-1:0]  word;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
    end else begin
      s1_v <= issue;
      s2_v <= s1_v;
    end
  end

  always_ff @(posedge clk) begin
    s1_half <= issue_half;
    s1_lane <= issue_lane_lo;
    s1_idx  <= issue_idx;
    s2_half <= s1_half;
    s2_lane <= s1_lane;
    s2_idx  <= s1_idx;
  end

  assign word    = s2_lane ? mem_rdata[HALF-1:0] : mem_rdata[DATA_W-1:HALF];
  assign wr_hi   = s2_v;
  assign wr_lo   = s2_v;
  assign wr_idx  = s2_idx;
  assign wr_data = s2_half ? {word, {HALF{1'b0}}} : mem_rdata;

endmodule

// File: rtl/hfp_regfile_unit.sv
module hfp_regfile_unit
  import hfp_rf_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 64,
  parameter int FIELD_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  op_valid,
  input  logic [7:0]            op_code,
  input  logic [FIELD_W-1:0]    op_r1,
  input  logic [FIELD_W-1:0]    op_r2,
  input  logic [ADDR_W-1:0]     op_addr,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  mem_rd_en,
  output logic                  mem_wr_en,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [DATA_W/8-1:0]   mem_be,
  output logic                  err_pulse
);

  localparam int IDX_W  = $clog2(NUM_REGS);
  localparam int BYTES  = DATA_W / 8;
  localparam int HALF_B = BYTES / 2;
  localparam int HALF   = DATA_W / 2;
  localparam int AL_W   = $clog2(BYTES);

  op_kind_e          kind;
  logic              dec_err;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              lane_lo;
  logic [DATA_W-1:0] rd_data;
  logic              is_load, is_store, is_copy;
  logic              ld_hi, ld_lo;
  logic [IDX_W-1:0]  ld_idx;
  logic [DATA_W-1:0] ld_data;

  hfp_op_decode #(
    .NUM_REGS(NUM_REGS), .FIELD_W(FIELD_W), .DATA_W(DATA_W)
  ) u_dec (
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_r1    (op_r1),
    .op_r2    (op_r2),
    .addr_lo  (op_addr[AL_W-1:0]),
    .kind     (kind),
    .err      (dec_err),
    .wr_idx   (wr_idx),
    .rd_idx   (rd_idx),
    .lane_lo  (lane_lo)
  );

  assign is_load  = (kind == K_LD64) || (kind == K_LD32);
  assign is_store = (kind == K_ST64) || (kind == K_ST32);
  assign is_copy  = (kind == K_CP64) || (kind == K_CP32);

  hfp_reg_bank #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)
  ) u_bank (
    .clk     (clk),
    .rst     (rst),
    .a_we_hi (is_copy),
    .a_we_lo (kind == K_CP64),
    .a_idx   (wr_idx),
    .a_data  (rd_data),
    .b_we_hi (ld_hi),
    .b_we_lo (ld_lo),
    .b_idx   (ld_idx),
    .b_data  (ld_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  hfp_load_path #(
    .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_load (
    .clk           (clk),
    .rst           (rst),
    .issue         (is_load),
    .issue_half    (kind == K_LD32),
    .issue_lane_lo (lane_lo),
    .issue_idx     (wr_idx),
    .mem_rdata     (mem_rdata),
    .wr_hi         (ld_hi),
    .wr_lo         (ld_lo),
    .wr_idx        (ld_idx),
    .wr_data       (ld_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      err_pulse <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else begin
      mem_rd_en <= is_load;
      mem_wr_en <= is_store;
      err_pulse <= dec_err;
      if (is_load || is_store)
        mem_addr <= op_addr;
      if (kind == K_ST64) begin
        mem_wdata <= rd_data;
        mem_be    <= '1;
      end else if (kind == K_ST32) begin
        mem_wdata <= {2{rd_data[DATA_W-1:HALF]}};
        mem_be    <= lane_lo ? {{HALF_B{1'b0}}, {HALF_B{1'b1}}}
                             : {{HALF_B{1'b1}}, {HALF_B{1'b0}}};
      end
    end
  end

endmodule

// File: rtl/hfp_regfile_unit_chk.sv
module hfp_regfile_unit_chk #(
  parameter int ADDR_W   = 16,
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 64,
  parameter int FIELD_W  = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                op_valid,
  input logic [7:0]          op_code,
  input logic [FIELD_W-1:0]  op_r1,
  input logic [FIELD_W-1:0]  op_r2,
  input logic [ADDR_W-1:0]   op_addr,
  input logic [DATA_W-1:0]   mem_rdata,
  input logic                mem_rd_en,
  input logic                mem_wr_en,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic [DATA_W-1:0]   mem_wdata,
  input logic [DATA_W/8-1:0] mem_be,
  input logic                err_pulse
);

  localparam int BYTES  = DATA_W / 8;
  localparam int HALF_B = BYTES / 2;
  localparam int AL_W   = $clog2(BYTES);
  localparam logic [BYTES-1:0] BE_HI = {{HALF_B{1'b1}}, {HALF_B{1'b0}}};
  localparam logic [BYTES-1:0] BE_LO = {{HALF_B{1'b0}}, {HALF_B{1'b1}}};

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !mem_rd_en && !mem_wr_en && !err_pulse);

  // R8
  err_suppress_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> !mem_rd_en && !mem_wr_en);

  // R8
  misalign_store_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == 8'h60 && op_addr[AL_W-1:0] != '0 |=> err_pulse && !mem_wr_en);

  // R6
  store_be_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (mem_be == '1 || mem_be == BE_HI || mem_be == BE_LO));

  // R7
  wide_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en && mem_be == '1 |-> mem_addr[AL_W-1:0] == '0);

  // R2
  read_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> mem_addr[AL_W-2:0] == '0);

  // R10
  load_request_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_code == 8'h68 && op_r1[0] == 1'b0 && (int'(op_r1) >> 1) < NUM_REGS
      && op_addr[AL_W-1:0] == '0
    |=> mem_rd_en && mem_addr == $past(op_addr) && !err_pulse);

  // R9
  unknown_op_chk: assert property (@(posedge clk) disable iff (rst)
    op_valid && !(op_code inside {8'h68, 8'h78, 8'h28, 8'h38, 8'h70, 8'h60})
    |=> !err_pulse && !mem_rd_en && !mem_wr_en);

endmodule

bind hfp_regfile_unit hfp_regfile_unit_chk #(
  .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .FIELD_W(FIELD_W)
) u_chk (.*);

// File: tb/hfp_regfile_unit_tb.sv
module hfp_regfile_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 19;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [7:0]  op_code;
  logic [3:0]  op_r1, op_r2;
  logic [15:0] op_addr;
  logic [63:0] mem_rdata;
  logic        mem_rd_en, mem_wr_en;
  logic [15:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_be;
  logic        err_pulse;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hfp_regfile_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_r1(op_r1), .op_r2(op_r2), .op_addr(op_addr), .mem_rdata(mem_rdata),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .err_pulse(err_pulse)
  );

  // synchronous memory model, byte 0 on bits 63:56
  logic [63:0] mem [32];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) mem[i] <= '0;
      mem[0]  <= 64'h4278E804A8000000;
      mem[1]  <= 64'h427B333341100000;
      mem[2]  <= 64'hC280800040600000;
      mem[11] <= 64'hAAAAAAAABBBBBBBB;
      for (int i = 16; i < 20; i++) mem[i] <= '1;
      mem_rdata <= '0;
    end else begin
      if (mem_rd_en) mem_rdata <= mem[mem_addr[7:3]];
      if (mem_wr_en)
        for (int b = 0; b < 8; b++)
          if (mem_be[b]) mem[mem_addr[7:3]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end
  end

  int err_cnt = 0;
  always @(posedge clk) if (!rst && err_pulse) err_cnt <= err_cnt + 1;

  int  total = 0;
  int  fails = 0;
  logic done = 1'b0;

  typedef struct packed {
    logic [7:0]  op;
    logic [3:0]  r1;
    logic [3:0]  r2;
    logic [15:0] addr;
    logic        exp_err;
    logic        chk;
    logic [4:0]  dw;
    logic [63:0] val;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{8'h68, 4'd2, 4'd0, 16'h0000, 1'b0, 1'b0, 5'd0,  64'h0,                4'd2},  // R2
    '{8'h60, 4'd2, 4'd0, 16'h0040, 1'b0, 1'b1, 5'd8,  64'h4278E804A8000000, 4'd7},  // R7
    '{8'h78, 4'd4, 4'd0, 16'h000C, 1'b0, 1'b0, 5'd0,  64'h0,                4'd3},  // R3
    '{8'h60, 4'd4, 4'd0, 16'h0048, 1'b0, 1'b1, 5'd9,  64'h4110000000000000, 4'd3},  // R3
    '{8'h78, 4'd0, 4'd0, 16'h0008, 1'b0, 1'b0, 5'd0,  64'h0,                4'd3},  // R3
    '{8'h38, 4'd2, 4'd0, 16'h0000, 1'b0, 1'b0, 5'd0,  64'h0,                4'd5},  // R5
    '{8'h60, 4'd2, 4'd0, 16'h0050, 1'b0, 1'b1, 5'd10, 64'h427B3333A8000000, 4'd5},  // R5
    '{8'h28, 4'd6, 4'd2, 16'h0000, 1'b0, 1'b0, 5'd0,  64'h0,                4'd4},  // R4
    '{8'h70, 4'd4, 4'd0, 16'h005C, 1'b0, 1'b1, 5'd11, 64'hAAAAAAAA41100000, 4'd6},  // R6
    '{8'h70, 4'd6, 4'd0, 16'h0058, 1'b0, 1'b1, 5'd11, 64'h427B333341100000, 4'd6},  // R6
    '{8'h60, 4'd6, 4'd0, 16'h0060, 1'b0, 1'b1, 5'd12, 64'h427B3333A8000000, 4'd4},  // R4
    '{8'h68, 4'd0, 4'd0, 16'h0004, 1'b1, 1'b0, 5'd0,  64'h0,                4'd8},  // R8
    '{8'h38, 4'd0, 4'd5, 16'h0000, 1'b1, 1'b0, 5'd0,  64'h0,                4'd8},  // R8
    '{8'h28, 4'd8, 4'd0, 16'h0000, 1'b1, 1'b0, 5'd0,  64'h0,                4'd8},  // R8
    '{8'h99, 4'd0, 4'd2, 16'h0000, 1'b0, 1'b0, 5'd0,  64'h0,                4'd9},  // R9
    '{8'h60, 4'd0, 4'd0, 16'h0068, 1'b0, 1'b1, 5'd13, 64'h427B333300000000, 4'd9},  // R9 R8
    '{8'h60, 4'd6, 4'd0, 16'h0074, 1'b1, 1'b1, 5'd14, 64'h0,                4'd8},  // R8
    '{8'h70, 4'd6, 4'd0, 16'h007A, 1'b1, 1'b1, 5'd15, 64'h0,                4'd8},  // R8
    '{8'h70, 4'd3, 4'd0, 16'h0070, 1'b1, 1'b1, 5'd14, 64'h0,                4'd8}   // R8
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] o, input logic [3:0] a, input logic [3:0] b,
                       input logic [15:0] ad);
    op_valid = 1'b1; op_code = o; op_r1 = a; op_r2 = b; op_addr = ad;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    op_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int base;
    rst = 1'b1; op_valid = 1'b0; op_code = '0; op_r1 = '0; op_r2 = '0; op_addr = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rd_en in reset", 64'(mem_rd_en), 64'd0);
    check("R1 wr_en in reset", 64'(mem_wr_en), 64'd0);
    check("R1 err in reset", 64'(err_pulse), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    // R1 all registers read back as zero
    for (int k = 0; k < 4; k++) drive(8'h60, 4'(2 * k), 4'd0, 16'(16'h0080 + 8 * k));
    idle(3);
    for (int k = 0; k < 4; k++) check("R1 register zero", mem[16 + k], 64'd0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      base = err_cnt;
      drive(VECS[i].op, VECS[i].r1, VECS[i].r2, VECS[i].addr);
      idle(4);
      check($sformatf("R%0d row %0d error count", VECS[i].req, i),
            64'(err_cnt - base), 64'(VECS[i].exp_err));
      if (VECS[i].chk)
        check($sformatf("R%0d row %0d memory", VECS[i].req, i), mem[VECS[i].dw], VECS[i].val);
    end

    // R8 pulse lasts exactly one cycle and suppresses the access
    drive(8'h68, 4'd0, 4'd0, 16'h0002);
    check("R8 err high", 64'(err_pulse), 64'd1);
    check("R8 no read", 64'(mem_rd_en), 64'd0);
    idle(1);
    check("R8 err one cycle", 64'(err_pulse), 64'd0);
    idle(2);

    // R10 write-back edge collides with a store read of the same register
    drive(8'h68, 4'd2, 4'd0, 16'h0010);
    check("R10 request next cycle", 64'(mem_rd_en), 64'd1);
    check("R10 request address", 64'(mem_addr), 64'h10);
    idle(1);
    drive(8'h60, 4'd2, 4'd0, 16'h0070);
    drive(8'h60, 4'd2, 4'd0, 16'h0078);
    idle(3);
    check("R10 old value on write edge", mem[14], 64'h427B3333A8000000);
    check("R10 new value next cycle", mem[15], 64'hC280800040600000);

    // R11 copy and load write-back on the same edge, same register
    drive(8'h68, 4'd4, 4'd0, 16'h0010);
    idle(1);
    drive(8'h28, 4'd4, 4'd6, 16'h0000);
    idle(3);
    drive(8'h60, 4'd4, 4'd0, 16'h0080);
    idle(3);
    check("R11 copy wins", mem[16], 64'h427B3333A8000000);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule